// File: doc/BRIEF.md
# MSI Event Queue Engine

This block collects message-signalled interrupt events for one interrupt group and appends each event's 32-bit data word to a 64-entry ring kept in system memory. The hardware is the producer: it owns the tail index, writes the word at the tail slot through a simple request/acknowledge memory write port, and advances the tail only once that write has been acknowledged. Software is the consumer: it reads the tail index, processes the entries from its head index up to the tail, then writes the new head index back.

A small register file sets the ring's 64-bit base address, the queue and interrupt enables, an optional per-queue interrupt gate for platforms that need one, and a sticky overflow flag. The interrupt output stays high while entries remain unconsumed and every enable is set. An event that arrives while the ring is full is dropped and recorded in the overflow flag. Turning the queue off returns both indices to zero.

Top module: `msi_evq_engine`

## Requirements
- R1: After reset the head and tail indices read 0, the status word reads 0, `irq` is low and `mem_wr_valid` is low.
- R2: An accepted event produces one memory write whose data is the event word and whose byte address is the 64-bit base ({BASE_HI at register 2, BASE_LO at register 1}) plus tail × 4.
- R3: The tail index advances by one only on the clock edge where the memory write is acknowledged; until then `mem_wr_valid` stays high with address and data unchanged, and no further event is accepted.
- R4: Writing register 3 sets the head index to bits [5:0] of the write data; registers 3 and 4 read head and tail zero-extended in bits [5:0]; writes to register 4 have no effect.
- R5: The status register (6) reports the pending count (tail − head modulo 64, which equals 64 − (head − tail) when tail < head) in bits [13:8].
- R6: When tail + 1 equals head modulo 64, an arriving event is dropped with no memory write, the tail is unchanged, and status bit 0 (overflow) is set; it stays set until software writes status with bit 0 = 1.
- R7: While control bit 0 (queue enable, register 0) is clear, `event_ready` is low, events are ignored, head writes are ignored and both indices are held at 0.
- R8: With the gate parameter set, `irq` also requires bit QUEUE_ID of register 5 to be 1.
- R9: The tail wraps from 63 to 0 and the write address wraps back to the base.
- R10: `irq` is high exactly while head differs from tail and control bits 0, 1 and 11 are all set (plus the R8 gate); it falls in the cycle after software writes head equal to tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| event_valid | input | 1 | Incoming event present |
| event_data | input | 32 | Event data word |
| event_ready | output | 1 | Engine can take an event this cycle |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_addr | output | 64 | Byte address of the ring slot |
| mem_wr_data | output | 32 | Word to store |
| mem_wr_ack | input | 1 | Memory write completed |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt to the processor |

## Verification
The checks assume the memory side raises `mem_wr_ack` only while a request is open, and that software neither rewrites the base registers nor clears the queue enable while a write is outstanding; under those conditions the write address always matches the current tail slot. The stimulus programs the base before enabling the queue, drives acknowledges only from a responder that sees an open request, and disables the queue only after `event_ready` has returned high. Acknowledge latency is varied between zero and several cycles so that the hold-until-acknowledge behaviour and the tail timing are both exercised.

// File: rtl/evq_pkg.sv
// Shared register indices, control bit positions and writer states for the
// event queue engine. Assumes a 3-bit register index.
package evq_pkg;
    localparam logic [2:0] RA_CTRL    = 3'd0;
    localparam logic [2:0] RA_BASE_LO = 3'd1;
    localparam logic [2:0] RA_BASE_HI = 3'd2;
    localparam logic [2:0] RA_HEAD    = 3'd3;
    localparam logic [2:0] RA_TAIL    = 3'd4;
    localparam logic [2:0] RA_GATE    = 3'd5;
    localparam logic [2:0] RA_STATUS  = 3'd6;

    localparam int CTRL_QEN_BIT  = 0;
    localparam int CTRL_EVT_BIT  = 1;
    localparam int CTRL_OUT_BIT  = 11;
    localparam int STAT_PEND_LSB = 8;

    typedef enum logic {WR_IDLE, WR_BUSY} wr_state_e;
endpackage

// File: rtl/evq_regs.sv
// Software-visible register file: control enables, ring base, interrupt gate
// bits, sticky overflow flag, head write strobe and the read mux.
// Assumes DATA_W-wide registers and a base address of two DATA_W halves.
module evq_regs
    import evq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int PTR_W      = 6,
    parameter int NUM_QUEUES = 6,
    localparam int BASE_W    = 2 * DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [2:0]            reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic [PTR_W-1:0]      head,
    input  logic [PTR_W-1:0]      tail,
    input  logic [PTR_W-1:0]      pending,
    input  logic                  ovf_set,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  q_en,
    output logic                  evt_ie,
    output logic                  out_ie,
    output logic [BASE_W-1:0]     base,
    output logic [NUM_QUEUES-1:0] gate,
    output logic                  head_wr,
    output logic [PTR_W-1:0]      head_wdata,
    output logic                  overflow
);
    logic [DATA_W-1:0] base_lo;
    logic [DATA_W-1:0] base_hi;
    logic              wr_ctrl, wr_lo, wr_hi, wr_gate, wr_stat;

    // Decode the write strobe per register.
    always_comb begin
        wr_ctrl = reg_wr_en && (reg_addr == RA_CTRL);
        wr_lo   = reg_wr_en && (reg_addr == RA_BASE_LO);
        wr_hi   = reg_wr_en && (reg_addr == RA_BASE_HI);
        wr_gate = reg_wr_en && (reg_addr == RA_GATE);
        wr_stat = reg_wr_en && (reg_addr == RA_STATUS);
        head_wr = reg_wr_en && (reg_addr == RA_HEAD);
    end

    assign head_wdata = reg_wdata[PTR_W-1:0];
    assign base       = {base_hi, base_lo};

    // Control enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_en   <= 1'b0;
            evt_ie <= 1'b0;
            out_ie <= 1'b0;
        end else if (wr_ctrl) begin
            q_en   <= reg_wdata[CTRL_QEN_BIT];
            evt_ie <= reg_wdata[CTRL_EVT_BIT];
            out_ie <= reg_wdata[CTRL_OUT_BIT];
        end
    end

    // Ring base address halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo <= '0;
            base_hi <= '0;
        end else begin
            if (wr_lo) base_lo <= reg_wdata;
            if (wr_hi) base_hi <= reg_wdata;
        end
    end

    // Per-queue interrupt gate bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       gate <= '0;
        else if (wr_gate) gate <= reg_wdata[NUM_QUEUES-1:0];
    end

    // Sticky overflow: a new drop wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                     overflow <= 1'b0;
        else if (ovf_set)               overflow <= 1'b1;
        else if (wr_stat && reg_wdata[0]) overflow <= 1'b0;
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CTRL_QEN_BIT] = q_en;
                reg_rdata[CTRL_EVT_BIT] = evt_ie;
                reg_rdata[CTRL_OUT_BIT] = out_ie;
            end
            RA_BASE_LO: reg_rdata = base_lo;
            RA_BASE_HI: reg_rdata = base_hi;
            RA_HEAD:    reg_rdata[PTR_W-1:0] = head;
            RA_TAIL:    reg_rdata[PTR_W-1:0] = tail;
            RA_GATE:    reg_rdata[NUM_QUEUES-1:0] = gate;
            RA_STATUS: begin
                reg_rdata[0] = overflow;
                reg_rdata[STAT_PEND_LSB +: PTR_W] = pending;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evq_ptrs.sv
// Head and tail indices of the ring with occupancy flags. The head is set
// only by software, the tail only by an acknowledged write. Assumes the ring
// depth is 2**PTR_W so index arithmetic wraps naturally.
module evq_ptrs #(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_en,
    input  logic             head_wr,
    input  logic [PTR_W-1:0] head_wdata,
    input  logic             tail_adv,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [PTR_W-1:0] pending,
    output logic             full,
    output logic             empty
);
    // Head index: cleared while disabled, loaded by software otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !q_en) head <= '0;
        else if (head_wr)    head <= head_wdata;
    end

    // Tail index: cleared while disabled, stepped on each committed write.
    always_ff @(posedge clk) begin
        if (!rst_n || !q_en) tail <= '0;
        else if (tail_adv)   tail <= tail + 1'b1;
    end

    // Occupancy from modular index difference.
    always_comb begin
        pending = tail - head;
        empty   = (tail == head);
        full    = (PTR_W'(tail + 1'b1) == head);
    end
endmodule

// File: rtl/evq_writer.sv
// Accepts one event at a time, drops it when the ring is full, otherwise
// issues a single memory write at the tail slot and holds it until the
// acknowledge. Assumes base and queue enable stay unchanged while busy.
module evq_writer
    import evq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PTR_W  = 6,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_en,
    input  logic              event_valid,
    input  logic [DATA_W-1:0] event_data,
    input  logic              full,
    input  logic [PTR_W-1:0]  tail,
    input  logic [ADDR_W-1:0] base,
    input  logic              mem_wr_ack,
    output logic              event_ready,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              tail_adv,
    output logic              ovf_set
);
    localparam int PAD_W = ADDR_W - PTR_W - 2;

    wr_state_e         state;
    logic              accept;
    logic [ADDR_W-1:0] slot_addr;

    // Handshake and slot address.
    always_comb begin
        event_ready  = q_en && (state == WR_IDLE);
        accept       = event_valid && event_ready;
        mem_wr_valid = (state == WR_BUSY);
        tail_adv     = mem_wr_valid && mem_wr_ack && q_en;
        ovf_set      = accept && full;
        slot_addr    = base + {{PAD_W{1'b0}}, tail, 2'b00};
    end

    // Write request state and captured address/data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= WR_IDLE;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            unique case (state)
                WR_IDLE: if (accept && !full) begin
                    state       <= WR_BUSY;
                    mem_wr_addr <= slot_addr;
                    mem_wr_data <= event_data;
                end
                WR_BUSY: if (mem_wr_ack) state <= WR_IDLE;
                default: state <= WR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msi_evq_engine.sv
// Top of the event queue engine: register file, ring indices, memory writer
// and interrupt generation. With GATE_EN set, the interrupt also needs the
// gate bit selected by QUEUE_ID.
module msi_evq_engine #(
    parameter int DATA_W     = 32,
    parameter int PTR_W      = 6,
    parameter int NUM_QUEUES = 6,
    parameter int QUEUE_ID   = 2,
    parameter bit GATE_EN    = 1'b1,
    localparam int ADDR_W    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              event_valid,
    input  logic [DATA_W-1:0] event_data,
    output logic              event_ready,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic                  q_en, evt_ie, out_ie, overflow;
    logic [ADDR_W-1:0]     base;
    logic [NUM_QUEUES-1:0] gate;
    logic                  head_wr, tail_adv, ovf_set, full, empty, gate_ok;
    logic [PTR_W-1:0]      head_wdata, head, tail, pending;

    evq_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W), .NUM_QUEUES(NUM_QUEUES)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .head(head), .tail(tail), .pending(pending),
        .ovf_set(ovf_set), .reg_rdata(reg_rdata), .q_en(q_en), .evt_ie(evt_ie),
        .out_ie(out_ie), .base(base), .gate(gate), .head_wr(head_wr),
        .head_wdata(head_wdata), .overflow(overflow)
    );

    evq_ptrs #(.PTR_W(PTR_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .q_en(q_en), .head_wr(head_wr),
        .head_wdata(head_wdata), .tail_adv(tail_adv), .head(head), .tail(tail),
        .pending(pending), .full(full), .empty(empty)
    );

    evq_writer #(.DATA_W(DATA_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .q_en(q_en), .event_valid(event_valid),
        .event_data(event_data), .full(full), .tail(tail), .base(base),
        .mem_wr_ack(mem_wr_ack), .event_ready(event_ready),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .tail_adv(tail_adv), .ovf_set(ovf_set)
    );

    // Optional per-queue gate on the interrupt.
    generate
        if (GATE_EN) begin : g_gate
            assign gate_ok = gate[QUEUE_ID];
        end else begin : g_nogate
            assign gate_ok = 1'b1;
        end
    endgenerate

    // Interrupt level while entries remain and all enables are set.
    always_comb irq = q_en && evt_ie && out_ie && gate_ok && !empty;
endmodule

// File: rtl/evq_checker.sv
// Properties of the event queue engine, attached to every instance by bind.
module evq_checker #(
    parameter int PTR_W  = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              q_en,
    input logic [PTR_W-1:0]  head,
    input logic [PTR_W-1:0]  tail,
    input logic              full,
    input logic              overflow,
    input logic [ADDR_W-1:0] base,
    input logic              event_valid,
    input logic              event_ready,
    input logic              mem_wr_valid,
    input logic              mem_wr_ack,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic              irq
);
    localparam int PAD_W = ADDR_W - PTR_W - 2;

    // R2: the open request targets the current tail slot.
    a_r2_slot_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && q_en) |-> mem_wr_addr == base + {{PAD_W{1'b0}}, tail, 2'b00});

    // R3: an unacknowledged request is held unchanged.
    a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ack) |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

    // R3: no tail movement without an acknowledge.
    a_r3_tail_still: assert property (@(posedge clk) disable iff (!rst_n)
        (q_en && !(mem_wr_valid && mem_wr_ack)) |=> tail == $past(tail));

    // R3: an acknowledge steps the tail by one.
    a_r3_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q_en && mem_wr_valid && mem_wr_ack) |=> tail == PTR_W'($past(tail) + 1'b1));

    // R6: a full ring produces no write.
    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (event_valid && event_ready && full) |=> !mem_wr_valid);

    // R6: overflow only rises after a dropped event.
    a_r6_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(event_valid && event_ready && full));

    // R7: disabled queue refuses events and clears both indices.
    a_r7_off_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !q_en |-> !event_ready);
    a_r7_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !q_en |=> (head == '0) && (tail == '0));

    // R10: interrupt only with unconsumed entries on an enabled queue.
    a_r10_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (head != tail) && q_en);
endmodule

bind msi_evq_engine evq_checker #(.PTR_W(PTR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .q_en(q_en), .head(head), .tail(tail), .full(full),
    .overflow(overflow), .base(base), .event_valid(event_valid),
    .event_ready(event_ready), .mem_wr_valid(mem_wr_valid), .mem_wr_ack(mem_wr_ack),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .irq(irq)
);

// File: tb/msi_evq_engine_test.sv
// Scoreboard bench: the event driver queues expected memory writes, the
// memory responder pops and compares them when it acknowledges.
module msi_evq_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        event_valid = 1'b0;
    logic [31:0] event_data = '0;
    logic        event_ready;
    logic        mem_wr_valid;
    logic [63:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_wr_ack = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    int ack_delay = 0;
    int exp_tail = 0;
    int exp_head = 0;
    logic [63:0] exp_base = 64'h0000_0012_8000_1000;
    logic [95:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_evq_engine uut (
        .clk(clk), .rst_n(rst_n), .event_valid(event_valid), .event_data(event_data),
        .event_ready(event_ready), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Driver: presents one event and records the expected write, if any.
    task automatic send_event(input logic [31:0] d);
        @(negedge clk);
        while (!event_ready) @(negedge clk);
        if (((exp_tail + 1) % DEPTH) != exp_head) begin
            exp_q.push_back({exp_base + 64'(exp_tail * 4), d});
            exp_tail = (exp_tail + 1) % DEPTH;
        end
        event_valid = 1'b1; event_data = d;
        @(negedge clk);
        event_valid = 1'b0;
        while (!event_ready) @(negedge clk);
    endtask

    // Monitor and memory responder: acknowledges after ack_delay cycles.
    initial begin
        int waited = 0;
        forever begin
            @(negedge clk);
            if (mem_wr_ack) begin
                mem_wr_ack = 1'b0;
            end else if (mem_wr_valid) begin
                if (waited < ack_delay) begin
                    waited++;
                end else begin
                    waited = 0;
                    if (exp_q.size() == 0) begin
                        total++; bad++;
                        $display("FAIL R6 unexpected write actual=%0h expected=none", mem_wr_addr);
                    end else begin
                        chk("R2 write addr/data", {mem_wr_addr, mem_wr_data}, exp_q.pop_front());
                    end
                    mem_wr_ack = 1'b1;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        reg_read(3'd3, rd); chk("R1 head", rd, 0);
        reg_read(3'd4, rd); chk("R1 tail", rd, 0);
        reg_read(3'd6, rd); chk("R1 status", rd, 0);
        chk("R1 irq", irq, 0);
        chk("R1 mem_wr_valid", mem_wr_valid, 0);

        // Program base, enable everything except the gate bit.
        reg_write(3'd1, exp_base[31:0]);
        reg_write(3'd2, exp_base[63:32]);
        reg_write(3'd0, 32'h0000_0803);
        reg_read(3'd0, rd); chk("R7 ctrl readback", rd, 32'h0803);

        send_event(32'hA5A5_0001);
        send_event(32'h0000_0020);
        send_event(32'hFFFF_FFFF);
        reg_read(3'd4, rd); chk("R4 tail after 3", rd, 3);
        reg_read(3'd6, rd); chk("R5 pending 3", rd, 32'h0000_0300);
        chk("R8 irq gated off", irq, 0);
        reg_write(3'd5, 32'h0000_0004);
        chk("R8 irq with gate bit", irq, 1);

        // R4: tail register is read-only.
        reg_write(3'd4, 32'h0000_0011);
        reg_read(3'd4, rd); chk("R4 tail write ignored", rd, 3);

        // R10: head catch-up clears the interrupt.
        reg_write(3'd3, 32'd3); exp_head = 3;
        chk("R10 irq drops", irq, 0);
        reg_read(3'd3, rd); chk("R4 head readback", rd, 3);

        // R3: slow acknowledge holds the tail.
        ack_delay = 3;
        @(negedge clk);
        exp_q.push_back({exp_base + 64'(exp_tail * 4), 32'h1234_5678});
        t0 = exp_tail; exp_tail = (exp_tail + 1) % DEPTH;
        event_valid = 1'b1; event_data = 32'h1234_5678;
        @(negedge clk);
        event_valid = 1'b0;
        chk("R3 request open", mem_wr_valid, 1);
        chk("R3 no new event while busy", event_ready, 0);
        reg_addr = 3'd4; #1 chk("R3 tail held before ack", reg_rdata, t0);
        while (!event_ready) @(negedge clk);
        reg_read(3'd4, rd); chk("R3 tail after ack", rd, t0 + 1);
        send_event(32'h0BAD_CAFE);
        ack_delay = 0;

        // R9 and R6: fill across the wrap, then overflow.
        reg_write(3'd3, 32'(exp_tail)); exp_head = exp_tail;
        for (int i = 0; i < DEPTH - 1; i++) send_event(32'hC000_0000 + 32'(i));
        reg_read(3'd4, rd); chk("R9 tail wrapped", rd, 4);
        reg_read(3'd6, rd); chk("R5 pending full", rd, 32'h0000_3F00);
        chk("R10 irq while pending", irq, 1);
        send_event(32'hDEAD_0000);
        reg_read(3'd4, rd); chk("R6 tail unchanged on drop", rd, 4);
        reg_read(3'd6, rd); chk("R6 overflow set", rd, 32'h0000_3F01);
        reg_write(3'd6, 32'h1);
        reg_read(3'd6, rd); chk("R6 overflow cleared", rd, 32'h0000_3F00);

        // R7: disabling clears indices and ignores events and head writes.
        reg_write(3'd0, 32'h0);
        exp_tail = 0; exp_head = 0;
        reg_read(3'd4, rd); chk("R7 tail cleared", rd, 0);
        reg_read(3'd3, rd); chk("R7 head cleared", rd, 0);
        chk("R7 not ready", event_ready, 0);
        @(negedge clk);
        event_valid = 1'b1; event_data = 32'h7777_7777;
        repeat (4) @(negedge clk);
        event_valid = 1'b0;
        reg_write(3'd3, 32'd7);
        reg_read(3'd3, rd); chk("R7 head write ignored", rd, 0);
        reg_read(3'd4, rd); chk("R7 event ignored", rd, 0);
        chk("R7 irq off", irq, 0);

        // R4/R5: masked head load, tail below head.
        reg_write(3'd0, 32'h0000_0803);
        reg_write(3'd3, 32'hFFFF_FFC5); exp_head = 5;
        reg_read(3'd3, rd); chk("R4 head masked", rd, 5);
        reg_read(3'd6, rd); chk("R5 pending wrapped", rd, 32'h0000_3B00);
        chk("R10 irq head ahead", irq, 1);

        repeat (4) @(negedge clk);
        chk("R2 all writes seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule